// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between a priority resolver and a CPU. It counts the CPU's acknowledge pulses and puts the matching vectoring byte on an 8-bit bus for each one. It supports two CPU styles. In the call style, three pulses return a call opcode, then the low byte and then the high byte of a 16-bit routine address. In the pointer style, two pulses are used: the first returns nothing and the second returns an 8-bit vector pointer.

The block raises the interrupt line to the CPU while the resolver reports a request. On the first pulse it tells the resolver which level won, and it gives a one-cycle strobe when the last pulse ends, which the resolver can use for automatic end-of-interrupt. The acknowledge input is synchronised inside the block, so every response follows an acknowledge edge by a fixed number of clocks. The mode and base inputs are configuration values and must not change during a sequence.

Top module: `intack_vector_seq`

## Requirements
- R1: After reset, `cpu_int`, `vec_oe`, `latch_stb` and `done_stb` are low and `vec_data` is zero.
- R2: While idle, a high `req_valid` raises `cpu_int`. It then stays high until the final acknowledge pulse of the sequence ends.
- R3: The first acknowledge pulse (falling edge of `ack_n`) gives exactly one single-cycle `latch_stb`, and `ack_level` shows the value `req_level` had at that moment.
- R4: If `req_valid` is low at the first pulse, `ack_level` is 7 (the highest level code), and every vector byte is the one level 7 would give.
- R5: With `cfg_mode16`=0 the sequence has three pulses. Pulse 1 drives 8'hCD, pulse 2 drives bits 7:0 and pulse 3 drives bits 15:8 of `(cfg_call_base + level*S) mod 65536`, where S is 8 if `cfg_step8`=1 and 4 if it is 0.
- R6: With `cfg_mode16`=1 the sequence has two pulses. Pulse 1 leaves `vec_oe` low, and pulse 2 drives `{cfg_ptr_hi, level}`, with the level in bits 2:0.
- R7: `done_stb` is a single-cycle pulse raised after the rising edge of the final pulse (pulse 3 in call style, pulse 2 in pointer style). It is never raised after an earlier pulse.
- R8: `cpu_int` is low in the cycle where `done_stb` is high. Afterwards it rises again if `req_valid` is still high, and stays low if it is not.
- R9: Acknowledge pulses that arrive while no interrupt is raised are ignored: no `vec_oe`, no strobes, `vec_data` stays zero, and the pulse counter does not advance.
- R10: `vec_oe` is high only while an acknowledge pulse of an active sequence is low and that pulse carries data. Whenever `vec_oe` is low, `vec_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode16 | input | 1 | 1 = two-pulse pointer style, 0 = three-pulse call style |
| cfg_step8 | input | 1 | Routine spacing in call style: 1 = 8 bytes, 0 = 4 bytes |
| cfg_call_base | input | 16 | Base routine address for call style |
| cfg_ptr_hi | input | 5 | Upper bits of the pointer byte for pointer style |
| req_valid | input | 1 | Resolver has a request that may interrupt the CPU |
| req_level | input | 3 | Winning level from the resolver |
| ack_n | input | 1 | Acknowledge pulse from the CPU, active low |
| cpu_int | output | 1 | Interrupt line to the CPU |
| vec_oe | output | 1 | Output enable for the vector bus |
| vec_data | output | 8 | Vector byte |
| latch_stb | output | 1 | One-cycle strobe: resolver latches `ack_level` into service |
| ack_level | output | 3 | Level being acknowledged |
| done_stb | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The bench builds the block with its default values: a 3-bit level, an 8-bit bus, two synchroniser stages and the additive address form. With an 8-level space, the bench can sweep every level, both spacings, both CPU styles and the missing-request case, and repeat the sweep over several bases. One base is chosen so that the level offset carries across the byte boundary and wraps past 16 bits. The sweep also alternates between keeping and dropping the request at the end of a sequence, so both re-raise and silence of the interrupt line are covered, along with pulses that arrive while idle.

// File: rtl/intack_pkg.sv
package intack_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_SEQ     = 2'd2,
      ST_RECOVER = 2'd3
   } seq_state_e;

   localparam int unsigned PULSE_CNT_W = 2;
   localparam logic [PULSE_CNT_W-1:0] CALL_LAST_PULSE = 2'd3;
   localparam logic [PULSE_CNT_W-1:0] PTR_LAST_PULSE  = 2'd2;

   function automatic logic [PULSE_CNT_W-1:0] last_pulse(input logic ptr_style);
      return ptr_style ? PTR_LAST_PULSE : CALL_LAST_PULSE;
   endfunction

endpackage

// File: rtl/intack_edge_det.sv
module intack_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_in,
   output logic ack_low,
   output logic ack_fall,
   output logic ack_rise
);

   logic synced;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = ack_n_in;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= ack_n_in;
         end
         assign synced = stage_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], ack_n_in};
         end
         assign synced = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= synced;
   end

   assign ack_low  = ~prev_q;
   assign ack_fall = prev_q & ~synced;
   assign ack_rise = ~prev_q & synced;

endmodule

// File: rtl/intack_seq_fsm.sv
module intack_seq_fsm
   import intack_pkg::*;
#(
   parameter int unsigned LEVEL_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [LEVEL_W-1:0]     req_level,
   input  logic                   mode16_in,
   input  logic                   ack_fall,
   input  logic                   ack_rise,
   output logic                   cpu_int,
   output logic                   in_seq,
   output logic [PULSE_CNT_W-1:0] pulse_idx,
   output logic [LEVEL_W-1:0]     level_q,
   output logic                   mode16_q,
   output logic                   latch_stb,
   output logic                   done_stb
);

   localparam logic [LEVEL_W-1:0] SPURIOUS_LEVEL = '1;

   seq_state_e             state_q;
   logic [PULSE_CNT_W-1:0] cnt_q;
   logic                   at_last;

   assign at_last = (cnt_q == last_pulse(mode16_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         level_q   <= '0;
         mode16_q  <= 1'b0;
         latch_stb <= 1'b0;
         done_stb  <= 1'b0;
      end else begin
         latch_stb <= 1'b0;
         done_stb  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) state_q <= ST_ARMED;
            end
            ST_ARMED: begin
               if (ack_fall) begin
                  state_q   <= ST_SEQ;
                  cnt_q     <= PULSE_CNT_W'(1);
                  level_q   <= req_valid ? req_level : SPURIOUS_LEVEL;
                  mode16_q  <= mode16_in;
                  latch_stb <= 1'b1;
               end
            end
            ST_SEQ: begin
               if (ack_fall && !at_last) begin
                  cnt_q <= cnt_q + PULSE_CNT_W'(1);
               end else if (ack_rise && at_last) begin
                  state_q  <= ST_RECOVER;
                  cnt_q    <= '0;
                  done_stb <= 1'b1;
               end
            end
            ST_RECOVER: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_int   = (state_q == ST_ARMED) || (state_q == ST_SEQ);
   assign in_seq    = (state_q == ST_SEQ);
   assign pulse_idx = cnt_q;

endmodule

// File: rtl/intack_byte_gen.sv
module intack_byte_gen
   import intack_pkg::*;
#(
   parameter int unsigned LEVEL_W     = 3,
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  CALL_OPCODE = 8'hCD,
   parameter int unsigned STEP_LO_LOG2 = 2,
   parameter int unsigned STEP_HI_LOG2 = 3,
   parameter bit          ADDR_ADDITIVE = 1'b1,
   localparam int unsigned ADDR_W     = 2 * DATA_W,
   localparam int unsigned PTR_HI_W   = DATA_W - LEVEL_W
) (
   input  logic                   active,
   input  logic                   mode16,
   input  logic [PULSE_CNT_W-1:0] pulse_idx,
   input  logic [LEVEL_W-1:0]     level,
   input  logic                   step_hi,
   input  logic [ADDR_W-1:0]      call_base,
   input  logic [PTR_HI_W-1:0]    ptr_hi,
   output logic                   oe,
   output logic [DATA_W-1:0]      data
);

   localparam int unsigned ADDR_BYTES = ADDR_W / DATA_W;

   logic [ADDR_W-1:0] lvl_ext;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] routine_addr;
   logic [DATA_W-1:0] addr_byte [ADDR_BYTES];
   logic [DATA_W-1:0] ptr_byte;
   logic [DATA_W-1:0] sel_byte;
   logic              has_data;

   assign lvl_ext = ADDR_W'(level);
   assign offset  = step_hi ? (lvl_ext << STEP_HI_LOG2) : (lvl_ext << STEP_LO_LOG2);

   generate
      if (ADDR_ADDITIVE) begin : g_add
         assign routine_addr = call_base + offset;
      end else begin : g_merge
         assign routine_addr = call_base | offset;
      end

      for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_bytes
         assign addr_byte[b] = routine_addr[b*DATA_W +: DATA_W];
      end
   endgenerate

   assign ptr_byte = {ptr_hi, level};

   always_comb begin
      sel_byte = '0;
      has_data = 1'b0;
      if (mode16) begin
         if (pulse_idx == PTR_LAST_PULSE) begin
            sel_byte = ptr_byte;
            has_data = 1'b1;
         end
      end else begin
         unique case (pulse_idx)
            2'd1: begin sel_byte = DATA_W'(CALL_OPCODE); has_data = 1'b1; end
            2'd2: begin sel_byte = addr_byte[0];         has_data = 1'b1; end
            2'd3: begin sel_byte = addr_byte[1];         has_data = 1'b1; end
            default: begin sel_byte = '0;                has_data = 1'b0; end
         endcase
      end
   end

   assign oe   = active & has_data;
   assign data = oe ? sel_byte : '0;

endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
   import intack_pkg::*;
#(
   parameter int unsigned LEVEL_W       = 3,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter logic [7:0]  CALL_OPCODE   = 8'hCD,
   parameter int unsigned STEP_LO_LOG2  = 2,
   parameter int unsigned STEP_HI_LOG2  = 3,
   parameter bit          ADDR_ADDITIVE = 1'b1,
   localparam int unsigned ADDR_W       = 2 * DATA_W,
   localparam int unsigned PTR_HI_W     = DATA_W - LEVEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_mode16,
   input  logic                cfg_step8,
   input  logic [ADDR_W-1:0]   cfg_call_base,
   input  logic [PTR_HI_W-1:0] cfg_ptr_hi,
   input  logic                req_valid,
   input  logic [LEVEL_W-1:0]  req_level,
   input  logic                ack_n,
   output logic                cpu_int,
   output logic                vec_oe,
   output logic [DATA_W-1:0]   vec_data,
   output logic                latch_stb,
   output logic [LEVEL_W-1:0]  ack_level,
   output logic                done_stb
);

   generate
      if (LEVEL_W < 1 || LEVEL_W >= DATA_W) begin : g_bad_level
         $error("intack_vector_seq: LEVEL_W must be in 1..DATA_W-1");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("intack_vector_seq: DATA_W must be 8");
      end
      if (STEP_HI_LOG2 + LEVEL_W > ADDR_W || STEP_LO_LOG2 > STEP_HI_LOG2) begin : g_bad_step
         $error("intack_vector_seq: spacing parameters out of range");
      end
   endgenerate

   logic                   ack_low;
   logic                   ack_fall;
   logic                   ack_rise;
   logic                   in_seq;
   logic [PULSE_CNT_W-1:0] pulse_idx;
   logic                   mode16_q;

   intack_edge_det #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_n_in (ack_n),
      .ack_low  (ack_low),
      .ack_fall (ack_fall),
      .ack_rise (ack_rise)
   );

   intack_seq_fsm #(
      .LEVEL_W (LEVEL_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_level (req_level),
      .mode16_in (cfg_mode16),
      .ack_fall  (ack_fall),
      .ack_rise  (ack_rise),
      .cpu_int   (cpu_int),
      .in_seq    (in_seq),
      .pulse_idx (pulse_idx),
      .level_q   (ack_level),
      .mode16_q  (mode16_q),
      .latch_stb (latch_stb),
      .done_stb  (done_stb)
   );

   intack_byte_gen #(
      .LEVEL_W       (LEVEL_W),
      .DATA_W        (DATA_W),
      .CALL_OPCODE   (CALL_OPCODE),
      .STEP_LO_LOG2  (STEP_LO_LOG2),
      .STEP_HI_LOG2  (STEP_HI_LOG2),
      .ADDR_ADDITIVE (ADDR_ADDITIVE)
   ) u_bytes (
      .active    (in_seq & ack_low),
      .mode16    (mode16_q),
      .pulse_idx (pulse_idx),
      .level     (ack_level),
      .step_hi   (cfg_step8),
      .call_base (cfg_call_base),
      .ptr_hi    (cfg_ptr_hi),
      .oe        (vec_oe),
      .data      (vec_data)
   );

endmodule

// File: rtl/intack_vector_seq_chk.sv
module intack_vector_seq_chk #(
   parameter int unsigned LEVEL_W = 3,
   parameter int unsigned DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_mode16,
   input logic               cpu_int,
   input logic               vec_oe,
   input logic [DATA_W-1:0]  vec_data,
   input logic               latch_stb,
   input logic [LEVEL_W-1:0] ack_level,
   input logic               done_stb
);

   assert_oe_in_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> cpu_int);

   assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_oe |-> (vec_data == '0));

   assert_latch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> !latch_stb);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> !done_stb);

   assert_int_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |-> !cpu_int);

   assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({latch_stb, done_stb}));

   assert_ptr_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && cfg_mode16) |-> (vec_data[LEVEL_W-1:0] == ack_level));

endmodule

bind intack_vector_seq intack_vector_seq_chk #(
   .LEVEL_W (LEVEL_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode16 (cfg_mode16),
   .cpu_int    (cpu_int),
   .vec_oe     (vec_oe),
   .vec_data   (vec_data),
   .latch_stb  (latch_stb),
   .ack_level  (ack_level),
   .done_stb   (done_stb)
);

// File: tb/intack_vector_seq_bench.sv
`timescale 1ns/1ps
module intack_vector_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode16 = 1'b0;
   logic        cfg_step8 = 1'b0;
   logic [15:0] cfg_call_base = 16'h0000;
   logic [4:0]  cfg_ptr_hi = 5'd0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_level = 3'd0;
   logic        ack_n = 1'b1;
   logic        cpu_int;
   logic        vec_oe;
   logic [7:0]  vec_data;
   logic        latch_stb;
   logic [2:0]  ack_level;
   logic        done_stb;

   int checks = 0;
   int errors = 0;
   int latch_cnt = 0;
   int done_cnt = 0;
   bit drop_seen = 1'b0;
   bit finished = 1'b0;

   logic [15:0] bases [3];
   logic [4:0]  ptrs  [3];

   always #10 clk = ~clk;

   intack_vector_seq u_intack_vector_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_mode16    (cfg_mode16),
      .cfg_step8     (cfg_step8),
      .cfg_call_base (cfg_call_base),
      .cfg_ptr_hi    (cfg_ptr_hi),
      .req_valid     (req_valid),
      .req_level     (req_level),
      .ack_n         (ack_n),
      .cpu_int       (cpu_int),
      .vec_oe        (vec_oe),
      .vec_data      (vec_data),
      .latch_stb     (latch_stb),
      .ack_level     (ack_level),
      .done_stb      (done_stb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // strobe monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (latch_stb) latch_cnt++;
         if (done_stb) begin
            done_cnt++;
            if (cpu_int) begin
               checks++;
               errors++;
               $display("FAIL R8: actual %0h expected %0h", cpu_int, 0);
            end else begin
               drop_seen = 1'b1;
            end
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_seq(input bit mode16, input bit step8, input int lvl,
                          input logic [15:0] base, input logic [4:0] phi,
                          input bit keep_req);
      bit          has_req;
      int          exp_lvl;
      int          npulses;
      logic [15:0] addr;
      bit          exp_oe;
      logic [7:0]  exp_data;
      has_req = (lvl < 8);
      exp_lvl = has_req ? lvl : 7;
      npulses = mode16 ? 2 : 3;
      addr = base + 16'(exp_lvl * (step8 ? 8 : 4));
      cfg_mode16 = mode16;
      cfg_step8 = step8;
      cfg_call_base = base;
      cfg_ptr_hi = phi;
      req_valid = 1'b1;
      req_level = has_req ? 3'(lvl) : 3'd2;
      wait_n(5);
      chk(cpu_int == 1'b1, "R2 raise", cpu_int, 1);
      if (!has_req) begin
         req_valid = 1'b0;   // R4: request gone before acknowledge
         wait_n(2);
      end
      latch_cnt = 0;
      done_cnt = 0;
      drop_seen = 1'b0;
      for (int p = 1; p <= npulses; p++) begin
         ack_n = 1'b0;
         wait_n(5);
         if (p == 1) begin
            chk(latch_cnt == 1, "R3 latch strobe", latch_cnt, 1);
            chk(ack_level == 3'(exp_lvl), has_req ? "R3 level" : "R4 level7",
                ack_level, exp_lvl);
         end
         if (mode16) begin
            exp_oe = (p == 2);
            exp_data = exp_oe ? {phi, 3'(exp_lvl)} : 8'h00;
         end else begin
            exp_oe = 1'b1;
            exp_data = (p == 1) ? 8'hCD : (p == 2) ? addr[7:0] : addr[15:8];
         end
         chk(vec_oe == exp_oe, mode16 ? "R6 oe" : "R5 oe", vec_oe, exp_oe);
         chk(vec_data == exp_data, mode16 ? "R6 byte" : "R5 byte", vec_data, exp_data);
         chk(cpu_int == 1'b1, "R2 held", cpu_int, 1);
         if (p == npulses && !keep_req) req_valid = 1'b0;
         ack_n = 1'b1;
         wait_n(5);
         chk(vec_oe == 1'b0 && vec_data == 8'h00, "R10 released", {vec_oe, vec_data}, 0);
         if (p < npulses) begin
            chk(done_cnt == 0, "R7 early", done_cnt, 0);
         end else begin
            chk(done_cnt == 1, "R7 final", done_cnt, 1);
            chk(drop_seen, "R8 drop", drop_seen, 1);
         end
      end
      chk(cpu_int == req_valid, "R8 after", cpu_int, req_valid);
      if (!req_valid) begin
         // R9: a stray pulse while nothing is raised
         ack_n = 1'b0;
         wait_n(5);
         chk(vec_oe == 1'b0 && vec_data == 8'h00, "R9 stray bus", {vec_oe, vec_data}, 0);
         chk(latch_cnt == 1 && cpu_int == 1'b0, "R9 stray state", latch_cnt, 1);
         ack_n = 1'b1;
         wait_n(5);
         chk(done_cnt == 1, "R9 stray done", done_cnt, 1);
      end
   endtask

   initial begin
      bases[0] = 16'h1230; bases[1] = 16'hFFE4; bases[2] = 16'h00F8;
      ptrs[0]  = 5'h15;    ptrs[1]  = 5'h0A;    ptrs[2]  = 5'h1F;
      wait_n(3);
      chk(cpu_int == 0 && vec_oe == 0 && vec_data == 0 && latch_stb == 0 && done_stb == 0,
          "R1 reset", {cpu_int, vec_oe, vec_data}, 0);
      rst_n = 1'b1;
      wait_n(3);
      chk(cpu_int == 0 && vec_oe == 0 && vec_data == 0, "R1 after release",
          {cpu_int, vec_oe, vec_data}, 0);
      // R9: pulses before any request
      for (int k = 0; k < 3; k++) begin
         ack_n = 1'b0;
         wait_n(5);
         chk(vec_oe == 0 && vec_data == 0 && cpu_int == 0, "R9 idle pulse",
             {cpu_int, vec_oe, vec_data}, 0);
         ack_n = 1'b1;
         wait_n(5);
      end
      chk(latch_cnt == 0 && done_cnt == 0, "R9 idle strobes", latch_cnt + done_cnt, 0);
      for (int b = 0; b < 3; b++)
         for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
               for (int l = 0; l <= 8; l++)
                  run_seq(m[0], s[0], l, bases[b], ptrs[b], (l % 3) != 0);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule